// File: doc/BRIEF.md
# Ping-Pong Descriptor DMA Channel

This block is a single one-shot DMA channel that owns two complete descriptor sets. Each set holds a start address, a word count and a command word. While the hardware runs a transfer from one set, software fills in the other set and marks it ready. When the running set's count reaches zero, the channel switches to the other set. Transfers queued this way follow one another with no idle gap on the channel.

The memory side is a single request/acknowledge pair. The channel asserts a request with the current word address and a direction bit. Each acknowledged word advances the address by one word and lowers the remaining count by one. When a set finishes, a sticky per-set done flag is raised, an interrupt is asserted if it is enabled, and the active-set pointer toggles. Software can read the pointer, so it always knows which set to refill next.

Register map on the 32-bit bus (byte offsets):

| Offset | Meaning |
|--------|---------|
| 0x00 | set 0 address |
| 0x04 | set 0 length |
| 0x08 | set 0 command |
| 0x0C | control |
| 0x10 | set 1 address |
| 0x14 | set 1 length |
| 0x18 | set 1 command |
| 0x1C | status |

Top module: `pingPongDma`

## Requirements
- R1: After reset, every register reads zero, the active pointer is set 0, the channel is idle, and `memReq` and `irq` are low.
- R2: Byte offset 0x00/0x10 is the address of set 0/1 and 0x04/0x14 is its length in words. Both read back as written. Offset 0x0C bit 0 is the interrupt enable. The command word at 0x08/0x18 reads bit 0 = ready and bit 1 = direction (1 = write to memory).
- R3: While a set is running and its length is nonzero, `memReq` is high, `memAddr` is the set's address register, and `memWrite` is its direction bit. Each cycle with `memAck` high adds 4 to that address and subtracts 1 from the length, and both are visible one cycle later.
- R4: A running set whose length is zero completes in the next clock edge without a request. Completion sets that set's sticky done flag (status bit 0 for set 0, bit 1 for set 1), clears its ready bit, and toggles the active pointer (status bit 2).
- R5: Writing 1 to bit 0 of a set's command word marks it ready. An idle channel starts only the set named by the active pointer, and its request appears one cycle after the ready bit is set. A ready set that is not the pointed one waits.
- R6: If the other set is ready, or is started in the same cycle the active set completes, the channel keeps running with no idle cycle (status bit 3, busy, stays 1).
- R7: If the other set is not ready when the active set completes, the channel goes idle with `memReq` low. It resumes as soon as that set is started.
- R8: While a set is running, writes to its address, length and command words have no effect. Writes to the idle set take effect.
- R9: `irq` equals the interrupt enable ANDed with (done0 OR done1). Writing 1 to status bit 0 or 1 clears the matching done flag.
- R10: Without `memAck`, `memReq` stays high and `memAddr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| regWr | input | 1 | register write strobe |
| regAddr | input | 5 | register byte offset |
| regWrData | input | 32 | register write data |
| regRdData | output | 32 | register read data (combinational) |
| memReq | output | 1 | memory word request |
| memAck | input | 1 | memory word acknowledge |
| memAddr | output | 32 | current word address |
| memWrite | output | 1 | direction of the current word |
| irq | output | 1 | interrupt |

## Verification
Two events can fall on the same clock edge: completion of the active set, and a software start of the other set. The bench programs a two-word set, acknowledges both words, and issues the start write to the idle set in exactly the cycle where the active length has reached zero. The result is correct if, one cycle later, the channel is still busy, the pointer has moved, and the request carries the second set's address. A channel that dropped the same-cycle start would instead go idle.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam int REG_AW = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } chState_e;

  // strobes from sequencing control to the descriptor datapath
  typedef struct packed {
    logic busy;
    logic actSet;
    logic step;
    logic complete;
  } ctlStrobes_t;
endpackage

// File: rtl/pingDmaRegs.sv
module pingDmaRegs
  import dmaPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  ctlStrobes_t       ctl,
  output logic [1:0]        readyFlags,
  output logic [1:0]        startPulse,
  output logic              lenZeroAct,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
  localparam logic [1:0] W_ADDR = 2'd0;
  localparam logic [1:0] W_LEN  = 2'd1;
  localparam logic [1:0] W_CMD  = 2'd2;
  localparam logic [1:0] W_MISC = 2'd3;

  logic [ADDR_W-1:0] addrOf [2];
  logic [LEN_W-1:0]  lenOf  [2];
  logic [1:0]        dirFlags;
  logic [1:0]        doneFlags;
  logic              irqEn;
  logic              wordOk;
  logic [1:0]        wordSel;

  assign wordOk  = (regAddr[1:0] == 2'b00);
  assign wordSel = regAddr[3:2];

  for (genvar s = 0; s < 2; s++) begin : g_set
    logic [ADDR_W-1:0] addrQ;
    logic [LEN_W-1:0]  lenQ;
    logic              dirQ;
    logic              readyQ;
    logic              doneQ;
    logic              setHit;
    logic              running;
    logic              mine;
    logic              clrDone;

    assign setHit  = regWr && wordOk && (regAddr[4] == 1'(s));
    assign mine    = (ctl.actSet == 1'(s));
    assign running = ctl.busy && mine;
    assign startPulse[s] = setHit && !running && (wordSel == W_CMD) && regWrData[0];
    assign clrDone = regWr && wordOk && (regAddr == 5'h1C) && regWrData[s];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ  <= '0;
        lenQ   <= '0;
        dirQ   <= 1'b0;
        readyQ <= 1'b0;
        doneQ  <= 1'b0;
      end else begin
        if (ctl.step && mine) begin
          addrQ <= addrQ + ADDR_STEP;
          lenQ  <= lenQ - 1'b1;
        end else if (setHit && !running) begin
          if (wordSel == W_ADDR) addrQ <= regWrData[ADDR_W-1:0];
          if (wordSel == W_LEN)  lenQ  <= regWrData[LEN_W-1:0];
        end
        if (setHit && !running && wordSel == W_CMD) dirQ <= regWrData[1];
        if (ctl.complete && mine)   readyQ <= 1'b0;
        else if (startPulse[s])     readyQ <= 1'b1;
        if (ctl.complete && mine)   doneQ <= 1'b1;
        else if (clrDone)           doneQ <= 1'b0;
      end
    end

    assign addrOf[s]     = addrQ;
    assign lenOf[s]      = lenQ;
    assign dirFlags[s]   = dirQ;
    assign readyFlags[s] = readyQ;
    assign doneFlags[s]  = doneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqEn <= 1'b0;
    else if (regWr && wordOk && regAddr == 5'h0C) irqEn <= regWrData[0];
  end

  assign lenZeroAct = (lenOf[ctl.actSet] == '0);
  assign memAddr    = addrOf[ctl.actSet];
  assign memWrite   = dirFlags[ctl.actSet];
  assign irq        = irqEn && (doneFlags != 2'b00);

  always_comb begin
    regRdData = '0;
    case (wordSel)
      W_ADDR: regRdData = 32'(addrOf[regAddr[4]]);
      W_LEN:  regRdData = 32'(lenOf[regAddr[4]]);
      W_CMD:  regRdData = {30'd0, dirFlags[regAddr[4]], readyFlags[regAddr[4]]};
      W_MISC: regRdData = regAddr[4] ? {28'd0, ctl.busy, ctl.actSet, doneFlags}
                                     : {31'd0, irqEn};
      default: regRdData = '0;
    endcase
  end

  // R3: an acknowledged word lowers the remaining count by one
  a_r3_len_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (lenOf[ctl.actSet] == $past(lenOf[ctl.actSet]) - 1'b1));

  // R3: an acknowledged word advances the address by one word
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (memAddr == $past(memAddr) + ADDR_STEP));

  // R4: completion leaves the finished set's done flag set
  a_r4_done_set: assert property (@(posedge clk) disable iff (!rstN)
    ctl.complete |=> doneFlags[$past(ctl.actSet)]);

  // R7: the channel never runs a set that is not marked ready
  a_r7_busy_ready: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |-> readyFlags[ctl.actSet]);
endmodule

// File: rtl/pingDmaCtl.sv
module pingDmaCtl
  import dmaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  readyFlags,
  input  logic [1:0]  startPulse,
  input  logic        lenZeroAct,
  input  logic        memAck,
  output ctlStrobes_t ctl,
  output logic        memReq
);
  chState_e state;
  logic     actQ;
  logic     running;
  logic     otherReady;

  assign running    = (state == ST_RUN);
  assign otherReady = readyFlags[~actQ] || startPulse[~actQ];

  always_comb begin
    memReq       = running && !lenZeroAct;
    ctl.busy     = running;
    ctl.actSet   = actQ;
    ctl.step     = memReq && memAck;
    ctl.complete = running && lenZeroAct;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      actQ  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (readyFlags[actQ]) state <= ST_RUN;
        ST_RUN: if (lenZeroAct) begin
          actQ  <= ~actQ;
          state <= otherReady ? ST_RUN : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an unanswered request is held
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R7: completion with nothing queued on the other side idles the channel
  a_r7_stop_unready: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.complete && !otherReady) |=> !ctl.busy);

  // R4: completion flips the active pointer
  a_r4_flip: assert property (@(posedge clk) disable iff (!rstN)
    ctl.complete |=> (ctl.actSet != $past(ctl.actSet)));
endmodule

// File: rtl/pingPongDma.sv
module pingPongDma
  import dmaPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [4:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReq,
  input  logic              memAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic              irq
);
  ctlStrobes_t ctl;
  logic [1:0]  readyFlags;
  logic [1:0]  startPulse;
  logic        lenZeroAct;

  pingDmaRegs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)
  ) uRegs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ctl(ctl),
    .readyFlags(readyFlags), .startPulse(startPulse), .lenZeroAct(lenZeroAct),
    .memAddr(memAddr), .memWrite(memWrite), .irq(irq)
  );

  pingDmaCtl uCtl (
    .clk(clk), .rstN(rstN), .readyFlags(readyFlags), .startPulse(startPulse),
    .lenZeroAct(lenZeroAct), .memAck(memAck), .ctl(ctl), .memReq(memReq)
  );
endmodule

// File: tb/pingPongDma_test.sv
`timescale 1ns/1ps
module pingPongDma_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq;
  logic        memAck = 1'b0;
  logic [31:0] memAddr;
  logic        memWrite;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pingPongDma uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAck(memAck), .memAddr(memAddr), .memWrite(memWrite), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    memAck = 1'b0; regWr = 1'b0;
    @(negedge clk); rstN = 1'b0;
    waitCyc(2);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    doReset();
    check("R1 memReq", {31'd0, memReq}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rdReg(5'h1C, v); check("R1 status", v, 0);
    rdReg(5'h00, v); check("R1 addr0", v, 0);
  endtask

  task automatic testRegs();
    logic [31:0] v;
    doReset();
    wrReg(5'h00, 32'h1234_5678);
    wrReg(5'h04, 32'h0000_ABCD);
    wrReg(5'h10, 32'h8765_4320);
    wrReg(5'h14, 32'h0000_0042);
    wrReg(5'h0C, 32'h1);
    rdReg(5'h00, v); check("R2 addr0", v, 32'h1234_5678);
    rdReg(5'h04, v); check("R2 len0", v, 32'hABCD);
    rdReg(5'h10, v); check("R2 addr1", v, 32'h8765_4320);
    rdReg(5'h14, v); check("R2 len1", v, 32'h42);
    rdReg(5'h0C, v); check("R2 ctrl", v, 32'h1);
    rdReg(5'h08, v); check("R2 cmd0 idle", v, 32'h0);
  endtask

  task automatic testTransfer();
    logic [31:0] v;
    doReset();
    wrReg(5'h00, 32'h1000);
    wrReg(5'h04, 32'd3);
    wrReg(5'h08, 32'h3);
    check("R5 no req in ready cycle", {31'd0, memReq}, 0);
    @(negedge clk);
    check("R3 req", {31'd0, memReq}, 1);
    check("R3 addr", memAddr, 32'h1000);
    check("R3 dir", {31'd0, memWrite}, 1);
    waitCyc(3);
    check("R10 req held", {31'd0, memReq}, 1);
    check("R10 addr stable", memAddr, 32'h1000);
    memAck = 1'b1;
    @(negedge clk);
    check("R3 addr step", memAddr, 32'h1004);
    rdReg(5'h04, v); check("R3 len step", v, 32'd2);
    waitCyc(2);
    memAck = 1'b0;
    check("R3 final addr", memAddr, 32'h100C);
    check("R4 no req at zero", {31'd0, memReq}, 0);
    @(negedge clk);
    rdReg(5'h1C, v); check("R4 done0 flip idle", v, 32'h5);
    rdReg(5'h08, v); check("R4 ready cleared", v, 32'h2);
  endtask

  task automatic testZeroLen();
    logic [31:0] v;
    int reqs = 0;
    doReset();
    wrReg(5'h08, 32'h1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (memReq) reqs++;
    end
    check("R4 zero-length no request", reqs, 0);
    rdReg(5'h1C, v); check("R4 zero-length done", v, 32'h5);
  endtask

  task automatic testWaitPointer();
    logic [31:0] v;
    doReset();
    memAck = 1'b1;
    wrReg(5'h14, 32'd1);
    wrReg(5'h18, 32'h1);
    waitCyc(4);
    check("R5 non-pointed set waits", {31'd0, memReq}, 0);
    rdReg(5'h1C, v); check("R5 still idle", v, 32'h0);
    rdReg(5'h18, v); check("R5 set1 ready", v, 32'h1);
    wrReg(5'h04, 32'd1);
    wrReg(5'h08, 32'h1);
    waitCyc(10);
    rdReg(5'h1C, v); check("R5 both ran in order", v, 32'h3);
  endtask

  task automatic testStopResume();
    logic [31:0] v;
    doReset();
    memAck = 1'b1;
    wrReg(5'h04, 32'd1);
    wrReg(5'h08, 32'h1);
    waitCyc(5);
    check("R7 stopped req", {31'd0, memReq}, 0);
    rdReg(5'h1C, v); check("R7 idle after set0", v, 32'h5);
    wrReg(5'h14, 32'd1);
    wrReg(5'h18, 32'h1);
    waitCyc(5);
    rdReg(5'h1C, v); check("R7 resumed set1", v, 32'h3);
  endtask

  task automatic testBackToBack();
    logic [31:0] v;
    logic [31:0] seen [4];
    int busyCyc = 0;
    int reqCyc = 0;
    doReset();
    memAck = 1'b1;
    wrReg(5'h00, 32'h2000); wrReg(5'h04, 32'd2);
    wrReg(5'h10, 32'h3000); wrReg(5'h14, 32'd2);
    wrReg(5'h18, 32'h1);
    wrReg(5'h08, 32'h1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rdReg(5'h1C, v);
      if (v[3]) busyCyc++;
      if (memReq) begin
        if (reqCyc < 4) seen[reqCyc] = memAddr;
        reqCyc++;
      end
    end
    check("R6 words", reqCyc, 4);
    check("R6 gapless busy", busyCyc, 6);
    check("R6 third word from set1", seen[2], 32'h3000);
    check("R6 fourth word", seen[3], 32'h3004);
  endtask

  task automatic testCollision();
    logic [31:0] v;
    doReset();
    wrReg(5'h00, 32'h4000); wrReg(5'h04, 32'd2);
    wrReg(5'h10, 32'h5000); wrReg(5'h14, 32'd3);
    wrReg(5'h08, 32'h1);
    @(negedge clk);
    memAck = 1'b1;
    waitCyc(2);
    check("R4 zero cycle no req", {31'd0, memReq}, 0);
    wrReg(5'h18, 32'h1);
    check("R6 same-cycle start keeps req", {31'd0, memReq}, 1);
    check("R6 same-cycle start addr", memAddr, 32'h5000);
    rdReg(5'h1C, v); check("R6 same-cycle status", v, 32'hD);
    memAck = 1'b0;
  endtask

  task automatic testActiveIgnored();
    logic [31:0] v;
    doReset();
    wrReg(5'h00, 32'h6000); wrReg(5'h04, 32'd5);
    wrReg(5'h08, 32'h1);
    @(negedge clk);
    wrReg(5'h00, 32'hDEAD_0000);
    wrReg(5'h04, 32'd9);
    wrReg(5'h08, 32'h3);
    wrReg(5'h10, 32'h7000);
    rdReg(5'h00, v); check("R8 active addr kept", v, 32'h6000);
    rdReg(5'h04, v); check("R8 active len kept", v, 32'd5);
    rdReg(5'h08, v); check("R8 active cmd kept", v, 32'h1);
    check("R8 memAddr kept", memAddr, 32'h6000);
    rdReg(5'h10, v); check("R8 idle set written", v, 32'h7000);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    doReset();
    memAck = 1'b1;
    wrReg(5'h0C, 32'h1);
    wrReg(5'h04, 32'd1);
    wrReg(5'h08, 32'h1);
    waitCyc(4);
    check("R9 irq on done", {31'd0, irq}, 1);
    wrReg(5'h1C, 32'h1);
    check("R9 irq cleared", {31'd0, irq}, 0);
    rdReg(5'h1C, v); check("R9 done0 cleared", v, 32'h4);
    wrReg(5'h0C, 32'h0);
    wrReg(5'h14, 32'd1);
    wrReg(5'h18, 32'h1);
    waitCyc(4);
    check("R9 masked irq", {31'd0, irq}, 0);
    wrReg(5'h0C, 32'h1);
    check("R9 irq after enable", {31'd0, irq}, 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish();
  end

  initial begin
    testReset();
    testRegs();
    testTransfer();
    testZeroLen();
    testWaitPointer();
    testStopResume();
    testBackToBack();
    testCollision();
    testActiveIgnored();
    testIrq();
    finish();
  end
endmodule